// File: doc/BRIEF.md
# SRAM DLL Bring-Up Sequencer

This controller-side block brings the internal delay-locked loop of a quad-data-rate SRAM to a usable state before the command scheduler may issue any access. After reset it switches on the supply enables in order: core rail, then I/O and reference rails together. It then waits for the board to report good power and a stable memory clock. It drives the device's DLL-off pin and the gate of the memory clocks, and it raises `ready` only after the DLL has been given a full lock interval.

A mode input selects one of two reset strategies. In pin mode the DLL-off pin is held low until power and clock are stable, then driven high. In tied mode that pin stays high, and the DLL is reset by stopping the memory clock for a time of at least 30 ns. A frequency-change request always forces a fresh DLL reset and a fresh lock interval. A request that arrives before `ready` is remembered and serviced after the lock in progress has finished. Loss of power-good sends the sequencer back to its first step.

Top module: `sram_dll_bringup`

## Requirements
- R1: During and right after reset the sequencer is in state code 0 (core rail step), with `coreEn`=1, `ioEn`=0, `refEn`=0, `dllCtl`=0, `clkGateEn`=0 and `ready`=0.
- R2: `ioEn` and `refEn` rise together exactly RAIL_GAP cycles (default 16) after reset is released, and neither is ever high while `coreEn` is low, nor `refEn` while `ioEn` is low.
- R3: In pin mode (`tiedMode`=0) `dllCtl` stays low in state 1 until `pwrGood` and `clkStable` are both high, and rises in the cycle after both are seen.
- R4: `ready` rises only after the lock step (state code 3) has lasted LOCK_CYC (default 1024) consecutive cycles with `clkStable` high and `clkGateEn` high.
- R5: A low `clkStable` during the lock step restarts the lock count from zero, so one dropped cycle at lock cycle d makes the step last d + LOCK_CYC cycles.
- R6: In tied mode (`tiedMode`=1) `dllCtl` is high from state 1 on, and the DLL reset step (state code 2) holds `clkGateEn` low for STOP_CYC cycles, where STOP_CYC is 30 ns divided by the clock period and rounded up (8 at 4 ns). The full lock step follows.
- R7: A `freqChgReq` high in the ready step (state code 4) drops `ready` in the next cycle and enters state code 2 for STOP_CYC cycles. In pin mode `dllCtl` is low and the clock runs; in tied mode the clock is gated and `dllCtl` is high. A full lock step follows.
- R8: A `freqChgReq` seen while not ready is latched. When the lock step in progress completes, the sequencer performs one more reset step and lock step instead of raising `ready`.
- R9: `pwrGood` low in state code 2, 3 or 4 returns the sequencer in the next cycle to state code 0, with the outputs as in R1 and any latched request dropped.
- R10: `stateCode` reports the step: 0 core rail, 1 rails on and waiting for stability, 2 DLL reset, 3 lock count, 4 ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same rate as the memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrGood | input | 1 | All supply rails are within tolerance |
| clkStable | input | 1 | Memory clock source is stable |
| freqChgReq | input | 1 | Operating frequency is being changed; relock needed |
| tiedMode | input | 1 | 0: DLL reset by pin, 1: pin held high, reset by clock stop |
| coreEn | output | 1 | Core supply enable |
| ioEn | output | 1 | I/O supply enable |
| refEn | output | 1 | Reference voltage enable |
| dllCtl | output | 1 | DLL-off control pin to the SRAM, low disables the DLL |
| clkGateEn | output | 1 | Enable for the memory clock gate |
| ready | output | 1 | Commands may be issued |
| stateCode | output | 3 | Current step code (see R10) |

## Verification
The bring-up is run in both modes, with a clean clock and with a single-cycle clock dropout early and late in the lock step. The lengths of the rail, stop and lock steps are measured at the ports, which separates a correct restart of the lock count from a count that merely pauses or ignores the dropout. Frequency changes are issued from ready in each mode and also during a lock, which shows whether a reset is done at once or deferred until the lock ends. Power loss is applied both in ready and in the middle of a lock.

// File: rtl/sram_dll_bringup_pkg.sv
package sram_dll_bringup_pkg;

  typedef enum logic [2:0] {
    ST_CORE  = 3'd0,
    ST_RAILS = 3'd1,
    ST_RESET = 3'd2,
    ST_LOCK  = 3'd3,
    ST_READY = 3'd4
  } seqState_t;

  typedef struct packed {
    logic clr;
    logic inc;
    logic pendSet;
    logic pendClr;
  } seqStrobe_t;

endpackage

// File: rtl/sram_dll_bringup_dp.sv
module sram_dll_bringup_dp
  import sram_dll_bringup_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  output logic [CW-1:0] cnt,
  output logic          pending
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clr) begin
      cnt <= '0;
    end else if (strobe.inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.pendClr) begin
      pending <= 1'b0;
    end else if (strobe.pendSet) begin
      pending <= 1'b1;
    end
  end

endmodule

// File: rtl/sram_dll_bringup_ctl.sv
module sram_dll_bringup_ctl
  import sram_dll_bringup_pkg::*;
#(
  parameter int CW       = 11,
  parameter int RAIL_GAP = 16,
  parameter int STOP_CYC = 8,
  parameter int LOCK_CYC = 1024
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pwrGood,
  input  logic          clkStable,
  input  logic          freqChgReq,
  input  logic          tiedMode,
  input  logic [CW-1:0] cnt,
  input  logic          pending,
  output seqStrobe_t    strobe,
  output logic          coreEn,
  output logic          ioEn,
  output logic          refEn,
  output logic          dllCtl,
  output logic          clkGateEn,
  output logic          ready,
  output logic [2:0]    stateCode
);

  localparam logic [CW-1:0] RAIL_LAST = CW'(RAIL_GAP - 1);
  localparam logic [CW-1:0] STOP_LAST = CW'(STOP_CYC - 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);

  seqState_t state, nextState;
  logic powerLost;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_CORE;
    else       state <= nextState;
  end

  assign powerLost = !pwrGood &&
                     (state == ST_RESET || state == ST_LOCK || state == ST_READY);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_CORE: begin
        strobe.inc = 1'b1;
        if (cnt == RAIL_LAST) nextState = ST_RAILS;
      end
      ST_RAILS: begin
        if (pwrGood && clkStable) nextState = tiedMode ? ST_RESET : ST_LOCK;
      end
      ST_RESET: begin
        strobe.inc = 1'b1;
        if (cnt == STOP_LAST) nextState = ST_LOCK;
      end
      ST_LOCK: begin
        if (!clkStable) begin
          strobe.clr = 1'b1;
        end else begin
          strobe.inc = 1'b1;
          if (cnt == LOCK_LAST) begin
            nextState      = pending ? ST_RESET : ST_READY;
            strobe.pendClr = pending;
          end
        end
      end
      ST_READY: begin
        if (freqChgReq) nextState = ST_RESET;
      end
      default: nextState = ST_CORE;
    endcase
    strobe.pendSet = freqChgReq && (state != ST_READY) && !powerLost;
    if (powerLost) begin
      nextState      = ST_CORE;
      strobe.pendClr = 1'b1;
    end
    if (nextState != state) strobe.clr = 1'b1;
  end

  always_comb begin
    coreEn    = 1'b1;
    ioEn      = (state != ST_CORE);
    refEn     = (state != ST_CORE);
    ready     = (state == ST_READY);
    stateCode = state;
    unique case (state)
      ST_CORE:  begin dllCtl = 1'b0;     clkGateEn = 1'b0;      end
      ST_RAILS: begin dllCtl = tiedMode; clkGateEn = 1'b1;      end
      ST_RESET: begin dllCtl = tiedMode; clkGateEn = !tiedMode; end
      default:  begin dllCtl = 1'b1;     clkGateEn = 1'b1;      end
    endcase
  end

endmodule

// File: rtl/sram_dll_bringup.sv
module sram_dll_bringup
  import sram_dll_bringup_pkg::*;
#(
  parameter int RAIL_GAP      = 16,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int STOP_MIN_PS   = 30000,
  parameter int LOCK_CYC      = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       clkStable,
  input  logic       freqChgReq,
  input  logic       tiedMode,
  output logic       coreEn,
  output logic       ioEn,
  output logic       refEn,
  output logic       dllCtl,
  output logic       clkGateEn,
  output logic       ready,
  output logic [2:0] stateCode
);

  localparam int STOP_CYC  = (STOP_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int MAX_A     = (RAIL_GAP > STOP_CYC) ? RAIL_GAP : STOP_CYC;
  localparam int MAX_CNT   = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
  localparam int CW        = $clog2(MAX_CNT + 1);

  seqStrobe_t    strobe;
  logic [CW-1:0] cnt;
  logic          pending;

  sram_dll_bringup_ctl #(
    .CW(CW), .RAIL_GAP(RAIL_GAP), .STOP_CYC(STOP_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .clkStable(clkStable),
    .freqChgReq(freqChgReq), .tiedMode(tiedMode), .cnt(cnt), .pending(pending),
    .strobe(strobe), .coreEn(coreEn), .ioEn(ioEn), .refEn(refEn),
    .dllCtl(dllCtl), .clkGateEn(clkGateEn), .ready(ready), .stateCode(stateCode)
  );

  sram_dll_bringup_dp #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(cnt), .pending(pending)
  );

endmodule

// File: rtl/sram_dll_bringup_chk.sv
module sram_dll_bringup_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwrGood,
  input logic       clkStable,
  input logic       freqChgReq,
  input logic       tiedMode,
  input logic       coreEn,
  input logic       ioEn,
  input logic       refEn,
  input logic       dllCtl,
  input logic       clkGateEn,
  input logic       ready,
  input logic [2:0] stateCode
);

  a_r2_io_after_core: assert property (@(posedge clk) disable iff (!rstN)
    ioEn |-> coreEn);

  a_r2_ref_with_io: assert property (@(posedge clk) disable iff (!rstN)
    refEn |-> ioEn);

  a_r3_pin_enable_when_stable: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dllCtl) && $past(stateCode) == 3'd1) |-> $past(pwrGood && clkStable));

  a_r4_ready_from_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(stateCode) == 3'd3 && $past(clkStable) && $past(clkGateEn)));

  a_r4_ready_with_clock: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (clkGateEn && dllCtl));

  a_r6_tied_stop_keeps_pin: assert property (@(posedge clk) disable iff (!rstN)
    (tiedMode && $fell(clkGateEn) && stateCode == 3'd2) |-> dllCtl);

  a_r7_freq_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (ready && freqChgReq && pwrGood) |=> (!ready && stateCode == 3'd2));

  a_r9_power_loss: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrGood && stateCode >= 3'd2) |=> (stateCode == 3'd0 && !ready && !dllCtl && !clkGateEn));

endmodule

bind sram_dll_bringup sram_dll_bringup_chk u_chk (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .clkStable(clkStable),
  .freqChgReq(freqChgReq), .tiedMode(tiedMode), .coreEn(coreEn), .ioEn(ioEn),
  .refEn(refEn), .dllCtl(dllCtl), .clkGateEn(clkGateEn), .ready(ready),
  .stateCode(stateCode)
);

// File: tb/sram_dll_bringup_bench.sv
module sram_dll_bringup_bench;

  localparam int RAIL = 16;
  localparam int STOP = (30000 + 4000 - 1) / 4000;
  localparam int LOCK = 1024;
  localparam int ROWS = 4;
  localparam int TBL_TIED [ROWS] = '{0, 1, 0, 1};
  localparam int TBL_DROP [ROWS] = '{0, 0, 100, 700};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrGood = 1'b0, clkStable = 1'b0, freqChgReq = 1'b0, tiedMode = 1'b0;
  logic coreEn, ioEn, refEn, dllCtl, clkGateEn, ready;
  logic [2:0] stateCode;
  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  sram_dll_bringup u_sram_dll_bringup (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .clkStable(clkStable),
    .freqChgReq(freqChgReq), .tiedMode(tiedMode), .coreEn(coreEn), .ioEn(ioEn),
    .refEn(refEn), .dllCtl(dllCtl), .clkGateEn(clkGateEn), .ready(ready),
    .stateCode(stateCode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges spent in one step; optional one-cycle clock drop or request
  task automatic countStep(input logic [2:0] code, input int dropAt, input int reqAt,
                           output int n);
    n = 0;
    while (stateCode == code && n < 5000) begin
      n++;
      if (n == dropAt) clkStable = 1'b0;
      if (n == reqAt)  freqChgReq = 1'b1;
      @(negedge clk);
      if (n == dropAt) clkStable = 1'b1;
      if (n == reqAt)  freqChgReq = 1'b0;
    end
  endtask

  task automatic bringUp(input int tied, input int dropAt, input int reqAt);
    int n;
    tiedMode = tied[0]; pwrGood = 1'b0; clkStable = 1'b0; freqChgReq = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(stateCode == 3'd0 && coreEn && !ioEn && !refEn && !dllCtl && !clkGateEn && !ready,
        "R1 reset state", int'(stateCode), 0);
    rstN = 1'b1;
    countStep(3'd0, 0, 0, n);
    chk(n == RAIL, "R2 core-to-io gap", n, RAIL);
    chk(ioEn && refEn && coreEn && stateCode == 3'd1, "R2 R10 rails on", int'(stateCode), 1);
    repeat (4) @(negedge clk);
    pwrGood = 1'b1;
    repeat (4) @(negedge clk);
    chk(stateCode == 3'd1 && dllCtl == tiedMode, "R3 dll pin waits for clock",
        int'(dllCtl), int'(tiedMode));
    clkStable = 1'b1;
    @(negedge clk);
    if (tied != 0) begin
      chk(stateCode == 3'd2 && !clkGateEn && dllCtl, "R6 clock stopped, pin high",
          int'(clkGateEn), 0);
      countStep(3'd2, 0, 0, n);
      chk(n == STOP, "R6 stop length", n, STOP);
    end else begin
      chk(stateCode == 3'd3 && dllCtl && clkGateEn, "R3 dll enabled next cycle",
          int'(stateCode), 3);
    end
    countStep(3'd3, dropAt, reqAt, n);
    chk(n == LOCK + dropAt, "R4 R5 lock length", n, LOCK + dropAt);
  endtask

  task automatic freqChange(input bit tied);
    int n;
    @(negedge clk);
    freqChgReq = 1'b1;
    @(negedge clk);
    freqChgReq = 1'b0;
    chk(!ready && stateCode == 3'd2, "R7 ready drops", int'(ready), 0);
    chk(dllCtl == tied && clkGateEn == !tied, "R7 reset style", int'(clkGateEn), int'(!tied));
    countStep(3'd2, 0, 0, n);
    chk(n == STOP, "R7 reset length", n, STOP);
    countStep(3'd3, 0, 0, n);
    chk(n == LOCK, "R7 relock length", n, LOCK);
    chk(ready && stateCode == 3'd4, "R7 ready again", int'(ready), 1);
  endtask

  initial begin
    int n;
    for (int i = 0; i < ROWS; i++) begin
      bringUp(TBL_TIED[i], TBL_DROP[i], 0);
      chk(ready && stateCode == 3'd4, "R4 R10 ready", int'(stateCode), 4);
    end

    // frequency change from ready, both modes
    bringUp(0, 0, 0);
    freqChange(1'b0);
    bringUp(1, 0, 0);
    freqChange(1'b1);

    // R8: request during lock is deferred
    bringUp(0, 0, 300);
    chk(!ready && stateCode == 3'd2, "R8 deferred reset", int'(stateCode), 2);
    countStep(3'd2, 0, 0, n);
    chk(n == STOP, "R8 reset length", n, STOP);
    countStep(3'd3, 0, 0, n);
    chk(n == LOCK, "R8 relock length", n, LOCK);
    chk(ready, "R8 ready after relock", int'(ready), 1);

    // R9: power loss in ready
    pwrGood = 1'b0;
    @(negedge clk);
    chk(stateCode == 3'd0 && !ready && !dllCtl && !clkGateEn && !ioEn && !refEn,
        "R9 loss in ready", int'(stateCode), 0);

    // R9: power loss mid-lock, pending request dropped
    rstN = 1'b0; tiedMode = 1'b0; pwrGood = 1'b0; clkStable = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    countStep(3'd0, 0, 0, n);
    pwrGood = 1'b1; clkStable = 1'b1;
    @(negedge clk);
    repeat (50) @(negedge clk);
    freqChgReq = 1'b1;
    @(negedge clk);
    freqChgReq = 1'b0; pwrGood = 1'b0;
    @(negedge clk);
    chk(stateCode == 3'd0 && !dllCtl && !clkGateEn, "R9 loss in lock", int'(stateCode), 0);
    pwrGood = 1'b1;
    countStep(3'd0, 0, 0, n);
    @(negedge clk);
    countStep(3'd3, 0, 0, n);
    chk(n == LOCK && stateCode == 3'd4, "R9 request cleared", int'(stateCode), 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

endmodule